// File: doc/BRIEF.md
# Serial ADC Conversion and Readout Controller

This block sits on the host side of a single-channel 12-bit serial analog-to-digital converter. When a start request arrives, it drives the active-low convert-start line low, which makes the converter hold its sample and begin converting. It then watches the converter's busy line until the conversion is finished. After that it produces a serial clock, shifts in a 16-bit frame and presents the 12-bit result together with a one-cycle valid pulse.

Two conversion styles are supported. In normal mode the convert-start line is released after a programmable low time, so the converter stays powered. In power-down mode the line is held low until the conversion is over, so the converter sleeps. The line is then raised to wake the converter before the data is read.

The first four bits of each frame must be zero; a non-zero bit among them raises a format flag. Start requests that arrive while a cycle is already running are dropped. If busy never completes within a programmable number of clocks, the cycle is abandoned and an error pulse is issued.

Top module: `serial_adc_reader`

## Requirements
- R1: After reset: convStN is high, sclk is low, and resultValid, timeoutErr and ctrlBusy are all low.
- R2: In normal mode (pdMode=0), an accepted start drives convStN low for exactly pwLen+1 clock cycles, after which it goes high again.
- R3: In power-down mode (pdMode=1), convStN stays low until busy has been seen high and then low. It therefore is still low when the conversion ends. It is high again before the first sclk rising edge.
- R4: sclk never goes high while the converter's busy line is high; readout starts only after busy has been seen to fall.
- R5: sclk idles low. Each frame has exactly 16 sclk high pulses, each sclkDiv+1 clocks long, and sclk is low again when resultValid is asserted.
- R6: Each data bit is taken at the moment the controller drives sclk low, MSB first. result equals the last 12 bits of the frame, unsigned straight binary. resultValid is a single-cycle pulse.
- R7: fmtErr, valid alongside resultValid, is 1 exactly when any of the frame's first four bits is 1.
- R8: ctrlBusy is high from the cycle after a start is accepted until the cycle resultValid rises, where it is low. A startReq that arrives while ctrlBusy is high is ignored: it causes no extra convStN falling edge, now or later.
- R9: If busy has not completed within timeoutLim clocks of the start, timeoutErr pulses and convStN returns high. No sclk edge and no resultValid follow, and the controller becomes idle.
- R10: Nothing on sdata after the 16th falling sclk edge affects the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request one conversion and readout |
| pdMode | input | 1 | 1: converter sleeps after each conversion |
| sclkDiv | input | DIV_W | Serial clock half period minus one, in clocks |
| pwLen | input | PW_W | Convert-start low time minus one, in clocks (normal mode) |
| timeoutLim | input | TO_W | Clocks allowed from start to end of busy |
| convStN | output | 1 | Active-low convert-start to the converter |
| adcBusy | input | 1 | Busy from the converter (asynchronous) |
| sclk | output | 1 | Serial clock to the converter |
| sdata | input | 1 | Serial data from the converter |
| result | output | DATA_W | Last conversion result |
| resultValid | output | 1 | One-cycle pulse when result updates |
| fmtErr | output | 1 | Leading bits of the last frame were not all zero |
| timeoutErr | output | 1 | One-cycle pulse when busy timed out |
| ctrlBusy | output | 1 | A conversion or readout cycle is in progress |

## Verification
A bad sequencer state shows up at the pins within a single conversion. A convert-start pulse of the wrong length, or a missing power-down hold, is visible on convStN several clocks before busy falls. A readout that starts early shows an sclk pulse while busy is high. A slip in the bit counter or the divider shows up by the end of that frame as a wrong pulse count, a wrong high time or a shifted result at the valid pulse. A start request that was not ignored shows up as a second convStN fall within a few clocks of the end of the cycle.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_READ,
    ST_DONE
  } ctrlState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic clear;   // reset divider, bit counter and shifter
    logic run;     // advance serial clock and shifter
    logic commit;  // latch result and format flag
  } dpStrobe_t;

endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int PW_W   = 8,
  parameter int TO_W   = 16,
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            pdMode,
  input  logic [PW_W-1:0] pwLen,
  input  logic [TO_W-1:0] timeoutLim,
  input  logic            adcBusy,
  input  logic            frameDone,
  output logic            convStN,
  output logic            ctrlBusy,
  output logic            timeoutErr,
  output dpStrobe_t       strobe
);

  localparam logic [PW_W-1:0] PW_ONE = PW_W'(1);
  localparam logic [TO_W-1:0] TO_ONE = TO_W'(1);

  ctrlState_t        state;
  logic [SYNC_N-1:0] busyPipe;
  logic              busySync;
  logic              convStQ;
  logic              sawBusy;
  logic              pdQ;
  logic              timeoutQ;
  logic [PW_W-1:0]   pwCnt;
  logic [TO_W-1:0]   toCnt;

  // busy arrives asynchronously from the converter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyPipe <= '0;
    else       busyPipe <= {busyPipe[SYNC_N-2:0], adcBusy};
  end
  assign busySync = busyPipe[SYNC_N-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      convStQ  <= 1'b1;
      sawBusy  <= 1'b0;
      pdQ      <= 1'b0;
      timeoutQ <= 1'b0;
      pwCnt    <= '0;
      toCnt    <= '0;
    end else begin
      timeoutQ <= 1'b0;
      case (state)
        ST_IDLE: if (startReq) begin
          state   <= ST_CONV;
          convStQ <= 1'b0;
          pwCnt   <= '0;
          toCnt   <= '0;
          sawBusy <= 1'b0;
          pdQ     <= pdMode;
        end
        ST_CONV: begin
          toCnt <= toCnt + TO_ONE;
          if (busySync) sawBusy <= 1'b1;
          if (toCnt == timeoutLim) begin
            timeoutQ <= 1'b1;
            convStQ  <= 1'b1;
            state    <= ST_IDLE;
          end else if (pdQ) begin
            if (sawBusy && !busySync) begin
              convStQ <= 1'b1;          // wake the converter
              state   <= ST_READ;
            end
          end else if (pwCnt == pwLen) begin
            convStQ <= 1'b1;
            state   <= ST_WAIT;
          end else begin
            pwCnt <= pwCnt + PW_ONE;
          end
        end
        ST_WAIT: begin
          toCnt <= toCnt + TO_ONE;
          if (busySync) sawBusy <= 1'b1;
          if (sawBusy && !busySync) begin
            state <= ST_READ;
          end else if (toCnt == timeoutLim) begin
            timeoutQ <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_READ: if (frameDone) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.clear  = (state != ST_READ);
  assign strobe.run    = (state == ST_READ);
  assign strobe.commit = (state == ST_DONE);
  assign convStN       = convStQ;
  assign ctrlBusy      = (state != ST_IDLE);
  assign timeoutErr    = timeoutQ;

  // R3: while sleeping is requested, the line stays low during busy
  p_pd_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && pdQ && busySync && toCnt != timeoutLim) |=> !convStQ);

  // R4: readout entered only after busy seen high then low
  p_read_after_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_READ) |-> ($past(sawBusy) && !$past(busySync)));

  // R8: a running cycle never restarts conversion without passing idle
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT || state == ST_READ || state == ST_DONE) |=> state != ST_CONV);

  // R9: timeout leaves the converter released and the sequencer idle
  p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    timeoutQ |-> (state == ST_IDLE && convStQ));

endmodule

// File: rtl/adc_rd_dpath.sv
module adc_rd_dpath
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LEAD_W = 4,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DIV_W-1:0]  sclkDiv,
  input  logic              sdataIn,
  output logic              sclk,
  output logic              frameDone,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              fmtErr
);

  localparam int FRAME_W = DATA_W + LEAD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam logic [DIV_W-1:0] DIV_ONE   = DIV_W'(1);

  logic [DIV_W-1:0]   divCnt;
  logic               sclkQ;
  logic [CNT_W-1:0]   edgeCnt;
  logic [FRAME_W-1:0] shiftQ;
  logic [DATA_W-1:0]  resultQ;
  logic               validQ;
  logic               fmtQ;
  logic               halfEnd;
  logic               fallNow;

  assign halfEnd   = (divCnt == sclkDiv);
  assign fallNow   = strobe.run && halfEnd && sclkQ;
  assign frameDone = fallNow && (edgeCnt == LAST_EDGE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      sclkQ   <= 1'b0;
      edgeCnt <= '0;
      shiftQ  <= '0;
      resultQ <= '0;
      validQ  <= 1'b0;
      fmtQ    <= 1'b0;
    end else begin
      validQ <= strobe.commit;
      if (strobe.commit) begin
        resultQ <= shiftQ[DATA_W-1:0];
        fmtQ    <= |shiftQ[FRAME_W-1:DATA_W];
      end
      if (strobe.clear) begin
        divCnt  <= '0;
        sclkQ   <= 1'b0;
        edgeCnt <= '0;
        shiftQ  <= '0;
      end else if (strobe.run) begin
        if (halfEnd) begin
          divCnt <= '0;
          sclkQ  <= ~sclkQ;
          if (sclkQ) begin
            // old bit still held by the converter at this falling edge
            shiftQ  <= {shiftQ[FRAME_W-2:0], sdataIn};
            edgeCnt <= edgeCnt + CNT_ONE;
          end
        end else begin
          divCnt <= divCnt + DIV_ONE;
        end
      end
    end
  end

  assign sclk        = sclkQ;
  assign result      = resultQ;
  assign resultValid = validQ;
  assign fmtErr      = fmtQ;

  // R6: valid is a single-cycle pulse
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    validQ |=> !validQ);

  // R5: serial clock back low by the time data is presented
  p_sclk_low_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> !sclkQ);

  // R10: no falling edge is counted past the frame length
  p_edge_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (edgeCnt < CNT_W'(FRAME_W)));

endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LEAD_W = 4,
  parameter int DIV_W  = 8,
  parameter int PW_W   = 8,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              pdMode,
  input  logic [DIV_W-1:0]  sclkDiv,
  input  logic [PW_W-1:0]   pwLen,
  input  logic [TO_W-1:0]   timeoutLim,
  output logic              convStN,
  input  logic              adcBusy,
  output logic              sclk,
  input  logic              sdata,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              fmtErr,
  output logic              timeoutErr,
  output logic              ctrlBusy
);

  dpStrobe_t strobe;
  logic      frameDone;

  adc_rd_ctrl #(.PW_W(PW_W), .TO_W(TO_W), .SYNC_N(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pdMode(pdMode),
    .pwLen(pwLen), .timeoutLim(timeoutLim), .adcBusy(adcBusy),
    .frameDone(frameDone), .convStN(convStN), .ctrlBusy(ctrlBusy),
    .timeoutErr(timeoutErr), .strobe(strobe)
  );

  adc_rd_dpath #(.DATA_W(DATA_W), .LEAD_W(LEAD_W), .DIV_W(DIV_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sclkDiv(sclkDiv),
    .sdataIn(sdata), .sclk(sclk), .frameDone(frameDone), .result(result),
    .resultValid(resultValid), .fmtErr(fmtErr)
  );

endmodule

// File: tb/serial_adc_reader_tb.sv
module serial_adc_reader_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        pdMode = 1'b0;
  logic [7:0]  sclkDiv = 8'd1;
  logic [7:0]  pwLen = 8'd0;
  logic [15:0] timeoutLim = 16'd400;
  logic        convStN, sclk, resultValid, fmtErr, timeoutErr, ctrlBusy;
  logic [11:0] result;

  // converter model state
  logic        busyM = 1'b0;
  logic        stuck = 1'b0;
  int          convCyc = 20;
  logic [15:0] frameM = '0;
  int          bitIdx = 0;
  logic        pdSeen = 1'b0;
  logic        sdataM;

  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  serial_adc_reader u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pdMode(pdMode),
    .sclkDiv(sclkDiv), .pwLen(pwLen), .timeoutLim(timeoutLim),
    .convStN(convStN), .adcBusy(busyM), .sclk(sclk), .sdata(sdataM),
    .result(result), .resultValid(resultValid), .fmtErr(fmtErr),
    .timeoutErr(timeoutErr), .ctrlBusy(ctrlBusy)
  );

  // converter: busy on convert-start fall, frame bits change after sclk fall
  always @(negedge convStN) begin
    if (!busyM) begin
      #1 busyM = 1'b1;
      repeat (convCyc) @(posedge clk);
      wait (!stuck);
      #3;
      pdSeen = !convStN;
      bitIdx = 0;
      busyM  = 1'b0;
    end
  end
  always @(negedge sclk) begin
    #2 bitIdx = bitIdx + 1;
  end
  assign sdataM = (bitIdx < 16) ? frameM[15 - bitIdx] : 1'b1;

  // port monitor, sampled mid-cycle
  int fallCnt = 0, lowCnt = 0, riseCnt = 0, sclkBusyErr = 0, convLowAtRise = 0;
  int halfErr = 0, validCnt = 0, toutCnt = 0, highLen = 0, curDiv = 1;
  logic [11:0] lastRes = '0;
  logic lastFmt = 1'b0, busyAtValid = 1'b0, sclkAtValid = 1'b0;
  logic prevConv = 1'b1, prevSclk = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevConv && !convStN) fallCnt++;
      if (!convStN) lowCnt++;
      if (!prevSclk && sclk) begin
        riseCnt++;
        if (busyM) sclkBusyErr++;
        if (!convStN) convLowAtRise++;
      end
      if (sclk) highLen = prevSclk ? highLen + 1 : 1;
      if (prevSclk && !sclk && highLen != curDiv + 1) halfErr++;
      if (resultValid) begin
        validCnt++;
        lastRes = result;
        lastFmt = fmtErr;
        busyAtValid = ctrlBusy;
        sclkAtValid = sclk;
      end
      if (timeoutErr) toutCnt++;
      prevConv = convStN;
      prevSclk = sclk;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expFmt(input logic [3:0] lead);
    return (lead != 4'd0) ? 1 : 0;
  endfunction

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic runConv(input bit pd, input logic [11:0] d, input logic [3:0] lead,
                         input int div, input int pw, input int cyc, input bit poke);
    int f0, l0, r0, sb0, cl0, h0, v0;
    @(negedge clk);
    pdMode = pd; sclkDiv = 8'(div); pwLen = 8'(pw); convCyc = cyc;
    frameM = {lead, d}; curDiv = div;
    f0 = fallCnt; l0 = lowCnt; r0 = riseCnt; sb0 = sclkBusyErr;
    cl0 = convLowAtRise; h0 = halfErr; v0 = validCnt;
    pulseStart();
    if (poke) begin
      repeat (4) @(negedge clk);
      chk("R8 ctrlBusy during cycle", int'(ctrlBusy), 1);
      pulseStart();
    end
    for (int i = 0; i < 3000 && validCnt == v0; i++) @(negedge clk);
    chk("R6 valid seen", validCnt - v0, 1);
    chk("R6 result", int'(lastRes), int'(d));
    chk("R7 fmtErr", int'(lastFmt), expFmt(lead));
    chk("R5 sclk pulses", riseCnt - r0, 16);
    chk("R5 half period", halfErr - h0, 0);
    chk("R5 sclk low at valid", int'(sclkAtValid), 0);
    chk("R4 sclk while busy", sclkBusyErr - sb0, 0);
    chk("R8 ctrlBusy at valid", int'(busyAtValid), 0);
    chk("R3 power-down seen", int'(pdSeen), int'(pd));
    chk("R3 convStN high at sclk", convLowAtRise - cl0, 0);
    if (!pd) chk("R2 convStN low width", lowCnt - l0, pw + 1);
    repeat (6) @(negedge clk);
    chk("R8 single conversion", fallCnt - f0, 1);
    chk("R6 valid pulse count", validCnt - v0, 1);
  endtask

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 convStN", int'(convStN), 1);
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 resultValid", int'(resultValid), 0);
    chk("R1 timeoutErr", int'(timeoutErr), 0);
    chk("R1 ctrlBusy", int'(ctrlBusy), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // directed corners
    runConv(1'b0, 12'h000, 4'h0, 2, 3, 15, 1'b0);   // R10: trailing ones must not leak in
    runConv(1'b0, 12'hFFF, 4'h0, 0, 0, 12, 1'b0);   // fastest clock
    runConv(1'b0, 12'hA5C, 4'h8, 1, 7, 20, 1'b0);   // R7 msb lead set
    runConv(1'b0, 12'h3C3, 4'h1, 3, 2, 14, 1'b0);   // R7 lsb lead set
    runConv(1'b1, 12'h801, 4'h0, 2, 0, 25, 1'b1);   // R3 power-down plus ignored start
    runConv(1'b0, 12'h7FE, 4'h0, 15, 5, 30, 1'b1);  // R8 slow clock with poke

    // constrained random
    for (int n = 0; n < 40; n++) begin
      logic [3:0] lead;
      lead = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      runConv(1'($urandom), 12'($urandom), lead, int'($urandom % 6),
              int'($urandom % 8), 12 + int'($urandom % 30), ($urandom % 3) == 0);
    end

    // R9 busy stuck high
    begin
      int t0, v0, r0;
      @(negedge clk);
      pdMode = 1'b0; pwLen = 8'd2; timeoutLim = 16'd25; stuck = 1'b1; convCyc = 5;
      t0 = toutCnt; v0 = validCnt; r0 = riseCnt;
      pulseStart();
      repeat (60) @(negedge clk);
      chk("R9 timeout pulse", toutCnt - t0, 1);
      chk("R9 convStN released", int'(convStN), 1);
      chk("R9 idle", int'(ctrlBusy), 0);
      stuck = 1'b0;
      repeat (30) @(negedge clk);
      chk("R9 no readout", riseCnt - r0, 0);
      chk("R9 no valid", validCnt - v0, 0);
      timeoutLim = 16'd400;
    end
    runConv(1'b1, 12'h5A5, 4'h0, 1, 0, 18, 1'b0);     // recovers after timeout

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

endmodule